// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the column addresses for that burst, one address per clock. A mode-set strobe programs three settings, which then hold until the next mode-set: a burst-length code, a burst-type bit and a single-write bit. A start strobe with a starting column then begins a burst. The block puts out one column per cycle, with a valid flag and a last-beat flag. Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. The order inside that block is either a wrapping count or an XOR pattern.

A full-page burst walks the whole column space, wrapping from the top column back to zero, and runs until a terminate strobe arrives. When single-write mode is set, a write request always gets exactly one address. A new start during a burst cuts the running burst off and begins the new one on the next cycle. Row and bank selection and command timing live elsewhere.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While rst_n is low at a clock edge, valid_o and last_o go low. The mode settings reset to burst length 1, sequential type, with single-write mode off.
- R2: The mode settings are loaded only at an edge where mode_set_i is high, and hold otherwise. Length codes on mode_bl_i: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give 1 beat. On mode_bt_i, 0 selects sequential and 1 selects interleave. A start in the same cycle as mode_set_i uses the old settings.
- R3: A start_i sampled at an edge gives valid_o high in the next cycle, with col_o equal to start_col_i. Beat k of the burst appears k cycles after beat 0.
- R4: In a sequential fixed burst of length BL = 2^L, the low L bits of beat k equal (start + k) mod BL. The upper column bits stay equal to those of the start column.
- R5: In an interleave fixed burst, the low L bits of beat k equal the low L bits of the start column XOR k. The upper bits are unchanged.
- R6: In a full-page burst, beat k is (start + k) mod 2^COL_W, so it wraps from the top column to 0. The burst-type bit is ignored in this mode, and the burst goes on until stop_i.
- R7: last_o is high on the final beat of a fixed-length burst. In the following cycle valid_o is low unless a new start was sampled.
- R8: stop_i high during a valid beat makes last_o high in that same cycle, and valid_o is low in the next cycle unless start_i was also high.
- R9: start_i during a burst truncates it. The next cycle shows beat 0 of the new burst at the new column.
- R10: When single-write mode is set, a start with wr_i high produces exactly one beat, whatever the length code. Reads, and writes when single-write mode is off, follow the programmed length.
- R11: last_o is never high while valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_set_i | input | 1 | Load the mode settings this cycle |
| mode_bl_i | input | 3 | Burst-length code |
| mode_bt_i | input | 1 | Burst type: 0 sequential, 1 interleave |
| mode_ws_i | input | 1 | Single-write mode enable |
| start_i | input | 1 | Begin a burst |
| start_col_i | input | COL_W | Starting column |
| wr_i | input | 1 | The starting burst is a write |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Final beat of the burst |

## Verification
The main check sweeps every starting column against each fixed length with both orderings. Sequential order and interleave order differ only when the start is not aligned, so the unaligned starts are what separate the two. They also show whether the upper bits stay put at the edge of a block. A full-page run starts near the top column and runs past the wrap. Directed patterns then try the other cases: a stop mid-burst, a restart mid-burst, a write and a read under single-write mode, reserved length codes, and mode inputs that change without a mode-set. Each of these isolates one control path from the address arithmetic.

// File: rtl/sdram_colgen_pkg.sv
// Package: shared configuration type and decode for the burst column
// generator. Assumes burst lengths up to 8 (COL_W >= 3).
package sdram_colgen_pkg;

    localparam logic [2:0] BLC_1    = 3'b000;
    localparam logic [2:0] BLC_2    = 3'b001;
    localparam logic [2:0] BLC_4    = 3'b010;
    localparam logic [2:0] BLC_8    = 3'b011;
    localparam logic [2:0] BLC_PAGE = 3'b111;

    // Per-burst configuration snapshot
    typedef struct packed {
        logic [1:0] lg;    // log2 of fixed burst length
        logic       full;  // full-page burst
        logic       itlv;  // interleaved ordering
    } burst_cfg_t;

    // Turns programmed mode plus request kind into the burst configuration
    function automatic burst_cfg_t decode_cfg(input logic [2:0] code,
                                              input logic       bt,
                                              input logic       ws,
                                              input logic       wr);
        burst_cfg_t c;
        logic       one_shot;
        one_shot = ws && wr;
        case (code)
            BLC_2:   c.lg = 2'd1;
            BLC_4:   c.lg = 2'd2;
            BLC_8:   c.lg = 2'd3;
            default: c.lg = 2'd0;
        endcase
        c.full = (code == BLC_PAGE) && !one_shot;
        if (one_shot) c.lg = 2'd0;
        c.itlv = bt && !c.full;
        return c;
    endfunction

endpackage

// File: rtl/colgen_mode_reg.sv
// Mode register: holds burst-length code, burst type and single-write
// enable. Loads only on mode_set_i; assumes synchronous active-low reset.
module colgen_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_set_i,
    input  logic [2:0] mode_bl_i,
    input  logic       mode_bt_i,
    input  logic       mode_ws_i,
    output logic [2:0] bl_o,
    output logic       bt_o,
    output logic       ws_o
);

    // Capture the mode fields on a mode-set cycle, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_o <= 3'b000;
            bt_o <= 1'b0;
            ws_o <= 1'b0;
        end else if (mode_set_i) begin
            bl_o <= mode_bl_i;
            bt_o <= mode_bt_i;
            ws_o <= mode_ws_i;
        end
    end

    // R2: without a mode-set the stored fields must not move
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_set_i) && $past(rst_n) |-> $stable(bl_o) && $stable(bt_o) && $stable(ws_o));

endmodule

// File: rtl/colgen_seq_ctrl.sv
// Burst sequencer: tracks base column, beat index and burst configuration.
// A start always wins over the end of a burst. Assumes the configuration
// is decoded by the caller and lg <= 3.
module colgen_seq_ctrl
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic             stop_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] beat_o,
    output burst_cfg_t       cfg_o
);

    logic [COL_W-1:0] last_idx;

    // Index of the final beat for the captured fixed length
    always_comb last_idx = COL_W'((4'd1 << cfg_o.lg) - 4'd1);

    // Final beat: end of fixed length, or a terminate sampled now
    always_comb last_o = valid_o && (stop_i || (!cfg_o.full && beat_o == last_idx));

    // Burst state: load on start, step each cycle, drop after the last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            base_o  <= '0;
            beat_o  <= '0;
            cfg_o   <= '0;
        end else if (start_i) begin
            valid_o <= 1'b1;
            base_o  <= start_col_i;
            beat_o  <= '0;
            cfg_o   <= cfg_i;
        end else if (valid_o) begin
            if (last_o) valid_o <= 1'b0;
            else        beat_o  <= beat_o + 1'b1;
        end
    end

    // R7/R8: after a final beat with no restart the burst is over
    a_r7_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !valid_o);

    // R8: a terminate during a beat must flag that beat as last
    a_r8_stop_last: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && stop_i |-> last_o);

    // R11: no last flag outside a burst
    a_r11_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

endmodule

// File: rtl/colgen_addr_map.sv
// Address map: forms the column for a beat from base column and beat
// index. Bits inside the burst block count (sequential) or XOR
// (interleave); bits above it keep the base. Full page adds across all bits.
module colgen_addr_map
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);

    localparam int BLK_BITS = 3;

    logic [COL_W-1:0] sum;

    // Wrapping sum shared by sequential and full-page orders
    always_comb sum = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < BLK_BITS) begin : g_low
            // Low bit: inside the block when below lg
            always_comb begin
                if (cfg_i.full)                   col_o[i] = sum[i];
                else if (i < int'(cfg_i.lg))      col_o[i] = cfg_i.itlv ? (base_i[i] ^ beat_i[i]) : sum[i];
                else                              col_o[i] = base_i[i];
            end
        end else begin : g_high
            // High bit: only full page lets the count reach it
            always_comb col_o[i] = cfg_i.full ? sum[i] : base_i[i];
        end
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
// Top: SDRAM burst column address generator. Mode register, burst
// sequencer and address map. Assumes COL_W >= 3; outputs are valid one
// cycle after start_i.
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_set_i,
    input  logic [2:0]       mode_bl_i,
    input  logic             mode_bt_i,
    input  logic             mode_ws_i,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             wr_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    logic [2:0]       m_bl;
    logic             m_bt;
    logic             m_ws;
    burst_cfg_t       req_cfg;
    burst_cfg_t       cur_cfg;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] beat;

    colgen_mode_reg i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_set_i (mode_set_i),
        .mode_bl_i  (mode_bl_i),
        .mode_bt_i  (mode_bt_i),
        .mode_ws_i  (mode_ws_i),
        .bl_o       (m_bl),
        .bt_o       (m_bt),
        .ws_o       (m_ws)
    );

    // Configuration for a burst that starts this cycle
    always_comb req_cfg = decode_cfg(m_bl, m_bt, m_ws, wr_i);

    colgen_seq_ctrl #(.COL_W(COL_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .cfg_i       (req_cfg),
        .stop_i      (stop_i),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .base_o      (base),
        .beat_o      (beat),
        .cfg_o       (cur_cfg)
    );

    colgen_addr_map #(.COL_W(COL_W)) i_map (
        .base_i (base),
        .beat_i (beat),
        .cfg_i  (cur_cfg),
        .col_o  (col_o)
    );

    // R3/R9: a start shows its own column on the next cycle
    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o && col_o == $past(start_col_i));

    // R4/R5: fixed bursts keep the bits above the block
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !cur_cfg.full && $past(valid_o) && !$past(start_i)
        |-> (col_o >> cur_cfg.lg) == ($past(col_o) >> cur_cfg.lg));

    // R6: full page steps by one with wrap
    a_r6_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && cur_cfg.full && $past(valid_o) && !$past(start_i)
        |-> col_o == $past(col_o) + 1'b1);

    // R10: a write in single-write mode is a one-beat burst
    a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && wr_i && m_ws |=> last_o);

endmodule

// File: tb/test_sdram_burst_colgen.sv
module test_sdram_burst_colgen;

    localparam int  COL_W  = 9;
    localparam int  NCOL   = 1 << COL_W;
    localparam time CLK_PS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_set_i = 1'b0;
    logic [2:0]       mode_bl_i = 3'b000;
    logic             mode_bt_i = 1'b0;
    logic             mode_ws_i = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             wr_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PS / 2) clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W)) i_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .mode_set_i(mode_set_i), .mode_bl_i(mode_bl_i),
        .mode_bt_i(mode_bt_i), .mode_ws_i(mode_ws_i), .start_i(start_i),
        .start_col_i(start_col_i), .wr_i(wr_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int base, int k, int lg, bit itlv, bit full);
        int bl;
        if (full) return (base + k) % NCOL;
        bl = 1 << lg;
        if (itlv) return (base / bl) * bl + ((base % bl) ^ k);
        return (base / bl) * bl + ((base + k) % bl);
    endfunction

    task automatic set_mode(input logic [2:0] bl, input bit bt, input bit ws);
        @(negedge clk);
        mode_set_i = 1'b1; mode_bl_i = bl; mode_bt_i = bt; mode_ws_i = ws;
        @(negedge clk);
        mode_set_i = 1'b0;
    endtask

    // Start a burst and check nbeats beats, then that the burst ended
    task automatic run_fixed(input string req, input int col, input bit wr,
                             input int nbeats, input int lg, input bit itlv);
        @(negedge clk);
        start_i = 1'b1; start_col_i = col[COL_W-1:0]; wr_i = wr;
        @(negedge clk);
        start_i = 1'b0; wr_i = 1'b0;
        for (int k = 0; k < nbeats; k++) begin
            chk({req, " valid"}, int'(valid_o), 1);
            chk({req, " col"}, int'(col_o), exp_col(col, k, lg, itlv, 1'b0));
            chk({req, " last (R7)"}, int'(last_o), (k == nbeats - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk({req, " ended (R7)"}, int'(valid_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(valid_o), 0);
        chk("R1 last in reset", int'(last_o), 0);
        rst_n = 1'b1;
        // R1: reset mode is one beat, sequential
        run_fixed("R1 reset mode", 13, 1'b0, 1, 0, 1'b0);

        // R4 R5: exhaustive sweep of starts, lengths and orderings
        for (int bt = 0; bt < 2; bt++) begin
            for (int lg = 0; lg < 4; lg++) begin
                set_mode(3'(lg), bt[0], 1'b0);
                for (int c = 0; c < NCOL; c++)
                    run_fixed(bt != 0 ? "R5 interleave" : "R4 sequential", c, 1'b0, 1 << lg, lg, bt[0]);
            end
        end

        // R2: reserved codes give one beat
        for (int code = 4; code < 7; code++) begin
            set_mode(3'(code), 1'b0, 1'b0);
            run_fixed("R2 reserved code", 77, 1'b0, 1, 0, 1'b0);
        end

        // R2: mode inputs changing without mode_set_i have no effect
        set_mode(3'b010, 1'b1, 1'b0);
        @(negedge clk);
        mode_bl_i = 3'b011; mode_bt_i = 1'b0;
        run_fixed("R2 mode held", 6, 1'b0, 4, 2, 1'b1);

        // R10: single-write mode: write is one beat, read follows length
        set_mode(3'b011, 1'b0, 1'b1);
        run_fixed("R10 single write", 21, 1'b1, 1, 0, 1'b0);
        run_fixed("R10 read in single-write mode", 21, 1'b0, 8, 3, 1'b0);
        set_mode(3'b011, 1'b0, 1'b0);
        run_fixed("R10 write burst", 21, 1'b1, 8, 3, 1'b0);

        // R8: stop at beat 3 of an 8-beat burst
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd42;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 pre-stop col", int'(col_o), exp_col(42, k, 3, 1'b0, 1'b0));
            @(negedge clk);
        end
        stop_i = 1'b1;
        #1;
        chk("R8 last on stop", int'(last_o), 1);
        chk("R8 col on stop", int'(col_o), exp_col(42, 3, 3, 1'b0, 1'b0));
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 ended after stop", int'(valid_o), 0);

        // R9: restart mid-burst
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd5;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 first col", int'(col_o), 5);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd300;
        chk("R9 beat before restart", int'(col_o), 6);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R9 restarted col", int'(col_o), exp_col(300, k, 3, 1'b0, 1'b0));
            chk("R9 restarted last", int'(last_o), (k == 7) ? 1 : 0);
            @(negedge clk);
        end
        chk("R9 ended", int'(valid_o), 0);

        // R6: full page with interleave bit set, wraps, runs until stop
        set_mode(3'b111, 1'b1, 1'b0);
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd500;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 530; k++) begin
            chk("R6 full page col", int'(col_o), exp_col(500, k, 0, 1'b0, 1'b1));
            chk("R6 full page no last", int'(last_o), 0);
            chk("R6 full page valid", int'(valid_o), 1);
            @(negedge clk);
        end
        stop_i = 1'b1;
        #1;
        chk("R8 full page stop last", int'(last_o), 1);
        @(negedge clk);
        stop_i = 1'b0;
        chk("R6 full page ended", int'(valid_o), 0);
        chk("R11 no last when idle", int'(last_o), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule